// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block decides where a small 8-bit processor core fetches next. Each cycle in which the decoder presents a flow-control operation, the unit looks at the current program counter, the 16-bit Z pointer, the status flags, a bit tested from a register or I/O location, the register-equality result and the two signed offset fields. From these it works out the next program counter, whether the flow was redirected, and how many cycles the instruction occupies.

Calls and returns do not store anything here. For a call the unit issues a push request that carries the return address. For a return it issues a pop request and takes the new PC from the stack data input. A return from interrupt also raises a request to set the global interrupt enable. Results are registered, so they appear one clock after the operation is presented.

Top module: `pcu_next`

## Requirements
- R1: While reset is asserted and until the first valid operation, every output is zero.
- R2: An operation presented with `op_valid` high appears on the outputs on the following clock, with `out_valid` high. When `op_valid` is low, `npc`, `taken`, `cycles` and `push_pc` keep their values, and `out_valid`, `push`, `pop` and `set_ie` are low in the next cycle.
- R3: The operation code 0 (plain sequential flow) gives `npc` = PC+1, `taken` = 0 and `cycles` = 1. All PC arithmetic wraps modulo 2^22.
- R4: Code 1 (relative jump) and code 2 (relative call) give `npc` = PC + sign-extended 12-bit `off_jmp` + 1 and `taken` = 1. The jump takes 2 cycles and the call takes 3.
- R5: Code 3 (indirect jump) and code 4 (indirect call) give `npc[15:0]` = `zptr` and `npc[21:16]` = 0. The jump takes 2 cycles and the call takes 3.
- R6: Codes 2 and 4 assert `push` with `push_pc` = PC+1. Code 5 (return) and code 6 (interrupt return) assert `pop`, load `npc` from `stack_pc` and take 4 cycles. Only code 6 asserts `set_ie`.
- R7: Code 7 branches when `sreg[bit_sel]` is 1, and code 8 branches when it is 0. The flag bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6 and I=7. A taken branch gives `npc` = PC + sign-extended 7-bit `off_br` + 1 and takes 2 cycles. A branch that is not taken gives PC+1 and takes 1 cycle.
- R8: Code 9 (signed greater-or-equal) is taken when N XOR V is 0. Code 10 (signed less-than) is taken when N XOR V is 1. The target and cycle counts are as in R7.
- R9: Code 11 (same-or-higher) is taken when C is 0. Code 12 (lower) is taken when C is 1. The target and cycle counts are as in R7.
- R10: Code 13 skips when `regs_equal` is 1. Code 14 skips when `test_bit` is 0, and code 15 skips when `test_bit` is 1. A skip gives PC+2 and 2 cycles, or PC+3 and 3 cycles when `next_two_word` is 1. A skip that does not happen gives PC+1 and 1 cycle.
- R11: `push` and `pop` are never high together. Each lasts exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 4 | Operation code (see requirements) |
| pc_in | input | 22 | Current program counter |
| zptr | input | 16 | Z pointer for indirect jumps and calls |
| sreg | input | 8 | Status flags |
| bit_sel | input | 3 | Selected flag for codes 7 and 8 |
| test_bit | input | 1 | Register or I/O bit under test for codes 14 and 15 |
| regs_equal | input | 1 | Compared registers are equal (code 13) |
| next_two_word | input | 1 | Instruction after a skip is two words long |
| off_br | input | 7 | Signed conditional-branch offset |
| off_jmp | input | 12 | Signed relative jump or call offset |
| stack_pc | input | 22 | Return address popped from the stack |
| out_valid | output | 1 | Result registers hold a new result |
| npc | output | 22 | Next program counter |
| taken | output | 1 | Flow was redirected |
| cycles | output | 3 | Cycle count of the instruction |
| push | output | 1 | Push request for a call |
| push_pc | output | 22 | Return address to push |
| pop | output | 1 | Pop request for a return |
| set_ie | output | 1 | Set the interrupt enable flag |

## Verification
The assertions assume that `stack_pc` already holds the popped address in the cycle the return is presented. They also assume that `pc_in` and the other operand inputs are stable across that clock edge. The bench drives every input half a clock away from the sampling edge, and for return operations it sets up the stack value together with the operation code, so both assumptions hold. It never presents an operation during reset, and the assertions about next-cycle results are disabled while reset is asserted.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [3:0] {
    OP_SEQ   = 4'd0,
    OP_RJMP  = 4'd1,
    OP_RCALL = 4'd2,
    OP_IJMP  = 4'd3,
    OP_ICALL = 4'd4,
    OP_RET   = 4'd5,
    OP_RETI  = 4'd6,
    OP_BFSET = 4'd7,
    OP_BFCLR = 4'd8,
    OP_BSGE  = 4'd9,
    OP_BSLT  = 4'd10,
    OP_BUHS  = 4'd11,
    OP_BULO  = 4'd12,
    OP_SKEQ  = 4'd13,
    OP_SKBC  = 4'd14,
    OP_SKBS  = 4'd15
  } op_kind_e;

  // flag positions inside the status byte
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;

  typedef enum logic [1:0] {
    CLS_FLOW   = 2'd0,  // sequential or unconditional redirect
    CLS_BRANCH = 2'd1,
    CLS_SKIP   = 2'd2
  } op_class_e;

  function automatic op_class_e classify(input op_kind_e k);
    case (k)
      OP_BFSET, OP_BFCLR, OP_BSGE, OP_BSLT, OP_BUHS, OP_BULO: return CLS_BRANCH;
      OP_SKEQ, OP_SKBC, OP_SKBS:                              return CLS_SKIP;
      default:                                                return CLS_FLOW;
    endcase
  endfunction

endpackage

// File: rtl/pcu_cond.sv
module pcu_cond
  import pcu_pkg::*;
#(
  parameter int unsigned SR_W  = 8,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input  op_kind_e          kind,
  input  logic [SR_W-1:0]   sreg,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              test_bit,
  input  logic              regs_equal,
  output logic              take
);

  logic flag_sel;
  logic lt_signed;

  always_comb begin
    flag_sel  = sreg[bit_sel];
    lt_signed = sreg[FLG_N] ^ sreg[FLG_V];
  end

  always_comb begin
    case (kind)
      OP_SEQ:   take = 1'b0;
      OP_RJMP,
      OP_RCALL,
      OP_IJMP,
      OP_ICALL,
      OP_RET,
      OP_RETI:  take = 1'b1;
      OP_BFSET: take = flag_sel;
      OP_BFCLR: take = ~flag_sel;
      OP_BSGE:  take = ~lt_signed;
      OP_BSLT:  take = lt_signed;
      OP_BUHS:  take = ~sreg[FLG_C];
      OP_BULO:  take = sreg[FLG_C];
      OP_SKEQ:  take = regs_equal;
      OP_SKBC:  take = ~test_bit;
      OP_SKBS:  take = test_bit;
      default:  take = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W  = 22,
  parameter int unsigned Z_W   = 16,
  parameter int unsigned BR_W  = 7,
  parameter int unsigned JMP_W = 12,
  localparam int unsigned BR_PAD  = PC_W - BR_W,
  localparam int unsigned JMP_PAD = PC_W - JMP_W,
  localparam int unsigned Z_PAD   = PC_W - Z_W
) (
  input  op_kind_e            kind,
  input  logic                take,
  input  logic                two_word,
  input  logic [PC_W-1:0]     pc,
  input  logic [Z_W-1:0]      zptr,
  input  logic [BR_W-1:0]     off_br,
  input  logic [JMP_W-1:0]    off_jmp,
  input  logic [PC_W-1:0]     stack_pc,
  output logic [PC_W-1:0]     npc,
  output logic [PC_W-1:0]     ret_addr
);

  logic [PC_W-1:0] br_ext;
  logic [PC_W-1:0] jmp_ext;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_br;
  logic [PC_W-1:0] pc_jmp;
  logic [PC_W-1:0] pc_skip;
  logic [PC_W-1:0] pc_ind;
  op_class_e       cls;

  always_comb begin
    br_ext  = {{BR_PAD{off_br[BR_W-1]}}, off_br};
    jmp_ext = {{JMP_PAD{off_jmp[JMP_W-1]}}, off_jmp};
    pc_inc  = pc + PC_W'(1);
    pc_br   = pc_inc + br_ext;
    pc_jmp  = pc_inc + jmp_ext;
    pc_skip = pc + (two_word ? PC_W'(3) : PC_W'(2));
    pc_ind  = {{Z_PAD{1'b0}}, zptr};
    cls     = classify(kind);
  end

  always_comb begin
    npc = pc_inc;
    case (kind)
      OP_RJMP, OP_RCALL: npc = pc_jmp;
      OP_IJMP, OP_ICALL: npc = pc_ind;
      OP_RET, OP_RETI:   npc = stack_pc;
      default: begin
        if (take && cls == CLS_BRANCH) npc = pc_br;
        else if (take && cls == CLS_SKIP) npc = pc_skip;
      end
    endcase
    ret_addr = pc_inc;
  end

endmodule

// File: rtl/pcu_cost.sv
module pcu_cost
  import pcu_pkg::*;
#(
  parameter int unsigned CYC_W    = 3,
  parameter int unsigned CYC_JMP  = 2,
  parameter int unsigned CYC_CALL = 3,
  parameter int unsigned CYC_RET  = 4
) (
  input  op_kind_e          kind,
  input  logic              take,
  input  logic              two_word,
  output logic [CYC_W-1:0]  cycles
);

  op_class_e cls;

  always_comb begin
    cls    = classify(kind);
    cycles = CYC_W'(1);
    case (kind)
      OP_RJMP, OP_IJMP:   cycles = CYC_W'(CYC_JMP);
      OP_RCALL, OP_ICALL: cycles = CYC_W'(CYC_CALL);
      OP_RET, OP_RETI:    cycles = CYC_W'(CYC_RET);
      default: begin
        if (take && cls == CLS_BRANCH)
          cycles = CYC_W'(2);
        else if (take && cls == CLS_SKIP)
          cycles = two_word ? CYC_W'(3) : CYC_W'(2);
      end
    endcase
  end

endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W  = 22,
  parameter int unsigned Z_W   = 16,
  parameter int unsigned SR_W  = 8,
  parameter int unsigned BR_W  = 7,
  parameter int unsigned JMP_W = 12,
  parameter int unsigned CYC_W = 3,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_kind,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [Z_W-1:0]    zptr,
  input  logic [SR_W-1:0]   sreg,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              test_bit,
  input  logic              regs_equal,
  input  logic              next_two_word,
  input  logic [BR_W-1:0]   off_br,
  input  logic [JMP_W-1:0]  off_jmp,
  input  logic [PC_W-1:0]   stack_pc,
  output logic              out_valid,
  output logic [PC_W-1:0]   npc,
  output logic              taken,
  output logic [CYC_W-1:0]  cycles,
  output logic              push,
  output logic [PC_W-1:0]   push_pc,
  output logic              pop,
  output logic              set_ie
);

  op_kind_e         kind;
  logic             take_c;
  logic [PC_W-1:0]  npc_c;
  logic [PC_W-1:0]  ret_c;
  logic [CYC_W-1:0] cyc_c;
  logic             push_c, pop_c, ie_c;

  assign kind = op_kind_e'(op_kind);

  pcu_cond #(.SR_W(SR_W)) u_cond (
    .kind       (kind),
    .sreg       (sreg),
    .bit_sel    (bit_sel),
    .test_bit   (test_bit),
    .regs_equal (regs_equal),
    .take       (take_c)
  );

  pcu_target #(.PC_W(PC_W), .Z_W(Z_W), .BR_W(BR_W), .JMP_W(JMP_W)) u_target (
    .kind     (kind),
    .take     (take_c),
    .two_word (next_two_word),
    .pc       (pc_in),
    .zptr     (zptr),
    .off_br   (off_br),
    .off_jmp  (off_jmp),
    .stack_pc (stack_pc),
    .npc      (npc_c),
    .ret_addr (ret_c)
  );

  pcu_cost #(.CYC_W(CYC_W)) u_cost (
    .kind     (kind),
    .take     (take_c),
    .two_word (next_two_word),
    .cycles   (cyc_c)
  );

  // stack side requests, qualified by the operation strobe
  always_comb begin
    push_c = op_valid && (kind == OP_RCALL || kind == OP_ICALL);
    pop_c  = op_valid && (kind == OP_RET || kind == OP_RETI);
    ie_c   = op_valid && (kind == OP_RETI);
  end

  // result registers, loaded only on a valid operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc     <= '0;
      taken   <= 1'b0;
      cycles  <= '0;
      push_pc <= '0;
    end else if (op_valid) begin
      npc     <= npc_c;
      taken   <= take_c;
      cycles  <= cyc_c;
      push_pc <= ret_c;
    end
  end

  // strobes, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      push      <= 1'b0;
      pop       <= 1'b0;
      set_ie    <= 1'b0;
    end else begin
      out_valid <= op_valid;
      push      <= push_c;
      pop       <= pop_c;
      set_ie    <= ie_c;
    end
  end

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!push && !pop && !set_ie)); // R2

  AST_IND_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_kind == 4'(OP_IJMP) || op_kind == 4'(OP_ICALL))
      |=> npc[PC_W-1:Z_W] == '0 && npc[Z_W-1:0] == $past(zptr)); // R5

  AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !take_c |=> npc == $past(pc_in) + PC_W'(1) && cycles == CYC_W'(1)); // R3

  AST_POP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_kind == 4'(OP_RET) || op_kind == 4'(OP_RETI))
      |=> pop && npc == $past(stack_pc)); // R6

  AST_SKIP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind >= 4'(OP_SKEQ) && take_c
      |=> cycles == (next_two_word_q ? CYC_W'(3) : CYC_W'(2))); // R10

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !op_valid |=> $stable(npc) && $stable(cycles)); // R2

  logic next_two_word_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) next_two_word_q <= 1'b0;
    else        next_two_word_q <= next_two_word;
  end

endmodule

// File: tb/sim_pcu_next.sv
module sim_pcu_next;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_kind;
  logic [21:0] pc_in;
  logic [15:0] zptr;
  logic [7:0]  sreg;
  logic [2:0]  bit_sel;
  logic        test_bit;
  logic        regs_equal;
  logic        next_two_word;
  logic [6:0]  off_br;
  logic [11:0] off_jmp;
  logic [21:0] stack_pc;
  logic        out_valid;
  logic [21:0] npc;
  logic        taken;
  logic [2:0]  cycles;
  logic        push;
  logic [21:0] push_pc;
  logic        pop;
  logic        set_ie;

  int n_chk = 0;
  int n_bad = 0;

  pcu_next u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [21:0] br_tgt(input logic [21:0] pc, input logic [6:0] o);
    return 22'(int'(pc) + int'($signed(o)) + 1);
  endfunction

  function automatic logic [21:0] jmp_tgt(input logic [21:0] pc, input logic [11:0] o);
    return 22'(int'(pc) + int'($signed(o)) + 1);
  endfunction

  task automatic idle_inputs();
    op_valid = 0; op_kind = 0; pc_in = 0; zptr = 0; sreg = 0; bit_sel = 0;
    test_bit = 0; regs_equal = 0; next_two_word = 0; off_br = 0; off_jmp = 0; stack_pc = 0;
  endtask

  // present one operation on a falling edge, sample on the next falling edge
  task automatic issue(input logic [3:0] k, input logic [21:0] pc);
    @(negedge clk);
    op_valid = 1; op_kind = k; pc_in = pc;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic expect_res(input string req, input logic [21:0] e_npc, input logic e_tk, input logic [2:0] e_cyc);
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "npc", 32'(npc), 32'(e_npc));
    chk(req, "taken", 32'(taken), 32'(e_tk));
    chk(req, "cycles", 32'(cycles), 32'(e_cyc));
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "npc", 32'(npc), 0);
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "cycles", 32'(cycles), 0);
    chk("R1", "push/pop/ie", 32'({push, pop, set_ie}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "npc after release", 32'(npc), 0);
  endtask

  task automatic t_seq();
    issue(4'd0, 22'h000123);
    expect_res("R3", 22'h000124, 0, 1);
    issue(4'd0, 22'h3FFFFF);
    expect_res("R3 wrap", 22'h000000, 0, 1);
  endtask

  task automatic t_rel();
    off_jmp = 12'h800;  // -2048
    issue(4'd1, 22'h001000);
    expect_res("R4 rjmp", jmp_tgt(22'h001000, 12'h800), 1, 2);
    chk("R4", "push on rjmp", 32'(push), 0);
    off_jmp = 12'h7FF;
    issue(4'd2, 22'h3FFF00);
    expect_res("R4 rcall", jmp_tgt(22'h3FFF00, 12'h7FF), 1, 3);
    chk("R6", "push on rcall", 32'(push), 1);
    chk("R6", "push_pc", 32'(push_pc), 32'(22'h3FFF01));
  endtask

  task automatic t_ind();
    zptr = 16'hBEEF;
    issue(4'd3, 22'h3F0000);
    expect_res("R5 ijmp", 22'h00BEEF, 1, 2);
    zptr = 16'h1234;
    issue(4'd4, 22'h250007);
    expect_res("R5 icall", 22'h001234, 1, 3);
    chk("R6", "push on icall", 32'(push), 1);
    chk("R6", "push_pc icall", 32'(push_pc), 32'(22'h250008));
  endtask

  task automatic t_ret();
    stack_pc = 22'h0ABCDE;
    issue(4'd5, 22'h000050);
    expect_res("R6 ret", 22'h0ABCDE, 1, 4);
    chk("R6", "pop ret", 32'(pop), 1);
    chk("R6", "set_ie ret", 32'(set_ie), 0);
    chk("R11", "push with pop", 32'(push), 0);
    stack_pc = 22'h000777;
    issue(4'd6, 22'h000060);
    expect_res("R6 reti", 22'h000777, 1, 4);
    chk("R6", "set_ie reti", 32'(set_ie), 1);
    @(negedge clk);
    chk("R11", "pop one cycle", 32'(pop), 0);
    chk("R2", "set_ie drops", 32'(set_ie), 0);
  endtask

  task automatic t_flagbr();
    off_br = 7'h40;  // -64
    for (int b = 0; b < 8; b++) begin
      bit_sel = 3'(b);
      sreg = 8'(1 << b);
      issue(4'd7, 22'h000200);
      expect_res("R7 set-taken", br_tgt(22'h000200, 7'h40), 1, 2);
      issue(4'd8, 22'h000200);
      expect_res("R7 clr-not", 22'h000201, 0, 1);
      sreg = ~8'(1 << b);
      issue(4'd8, 22'h000300);
      expect_res("R7 clr-taken", br_tgt(22'h000300, 7'h40), 1, 2);
    end
    off_br = 7'h3F;
    bit_sel = 3'd1;
    sreg = 8'h00;
    issue(4'd7, 22'h000010);
    expect_res("R7 set-not", 22'h000011, 0, 1);
  endtask

  task automatic t_signed();
    off_br = 7'h05;
    for (int v = 0; v < 4; v++) begin
      logic nx;
      sreg = 8'h00;
      sreg[2] = v[0];
      sreg[3] = v[1];
      sreg[4] = 1'b1;  // S must not matter
      nx = v[0] ^ v[1];
      issue(4'd9, 22'h000400);
      expect_res("R8 ge", nx ? 22'h000401 : br_tgt(22'h000400, 7'h05), !nx, nx ? 3'd1 : 3'd2);
      issue(4'd10, 22'h000400);
      expect_res("R8 lt", nx ? br_tgt(22'h000400, 7'h05) : 22'h000401, nx, nx ? 3'd2 : 3'd1);
    end
  endtask

  task automatic t_unsigned();
    off_br = 7'h7F;
    sreg = 8'hFE;  // C clear, rest set
    issue(4'd11, 22'h000000);
    expect_res("R9 sh taken", br_tgt(22'h000000, 7'h7F), 1, 2);
    issue(4'd12, 22'h000000);
    expect_res("R9 lo not", 22'h000001, 0, 1);
    sreg = 8'h01;
    issue(4'd12, 22'h000100);
    expect_res("R9 lo taken", br_tgt(22'h000100, 7'h7F), 1, 2);
    issue(4'd11, 22'h000100);
    expect_res("R9 sh not", 22'h000101, 0, 1);
  endtask

  task automatic t_skip();
    regs_equal = 1; next_two_word = 0;
    issue(4'd13, 22'h000500);
    expect_res("R10 eq 1w", 22'h000502, 1, 2);
    next_two_word = 1;
    issue(4'd13, 22'h000500);
    expect_res("R10 eq 2w", 22'h000503, 1, 3);
    regs_equal = 0;
    issue(4'd13, 22'h000500);
    expect_res("R10 ne", 22'h000501, 0, 1);
    test_bit = 0;
    issue(4'd14, 22'h3FFFFE);
    expect_res("R10 bc 2w wrap", 22'h000001, 1, 3);
    issue(4'd15, 22'h000600);
    expect_res("R10 bs not", 22'h000601, 0, 1);
    test_bit = 1; next_two_word = 0;
    issue(4'd15, 22'h000600);
    expect_res("R10 bs 1w", 22'h000602, 1, 2);
    issue(4'd14, 22'h000600);
    expect_res("R10 bc not", 22'h000601, 0, 1);
  endtask

  task automatic t_hold();
    issue(4'd2, 22'h000900);  // call with previous off_jmp
    @(negedge clk);
    op_valid = 0; op_kind = 4'd3; zptr = 16'hFFFF; pc_in = 22'h123456;
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 0);
    chk("R2", "npc held", 32'(npc), 32'(jmp_tgt(22'h000900, off_jmp)));
    chk("R2", "cycles held", 32'(cycles), 3);
    chk("R2", "push_pc held", 32'(push_pc), 32'(22'h000901));
    chk("R2", "push idle", 32'(push), 0);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_rel();
    t_ind();
    t_ret();
    t_flagbr();
    t_signed();
    t_unsigned();
    t_skip();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule